// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This block sits behind a clock-and-data recovery stage and works at the bit rate. Each cycle with the bit-valid input high, it takes one recovered serial bit. It assembles the bits into 10-bit characters and delivers each character on the parallel output with a one-cycle strobe. Alongside each character it gives a half-word slot flag and a comma flag. The slot flag alternates between two slots, so downstream logic can take characters in pairs.

While detection is enabled, the block compares the seven most recent bits against the synchronization comma on every accepted bit. When it finds the comma, it reframes the character boundary so that the comma starts a character. It also forces the half-word slot so that the comma character always appears in slot 1. A comma that is already correctly framed and already in slot 1 needs no correction. While detection is disabled, the current framing is kept, whatever bits arrive.

Top module: `cdwa_align`

## Requirements
- R1: While `rst_ni` is low, `char_o` is 0, and `char_vld_o`, `slot_o` and `comma_o` are 0.
- R2: Bit 0 of `char_o` holds the earliest received bit of the character. `char_vld_o` is high for one cycle per completed character. `char_o`, `slot_o` and `comma_o` change only in a cycle where `char_vld_o` is high, and hold their values between strobes.
- R3: A cycle with `bit_en_i` low does not advance the block. `bit_i` is ignored in that cycle, and `char_vld_o` is low in the following cycle.
- R4: The comma is the 7-bit sequence 0,0,1,1,1,1,1 in arrival order. Detection compares against it on every accepted bit while `det_en_i` is high. A framed comma character therefore has `char_o[6:0]` = 7'b1111100.
- R5: After a comma is detected, the comma character is delivered with the comma in bits 0 to 6. Every following character is framed on the 10-bit boundary that follows from it. At most three characters before the comma may be corrupted or dropped.
- R6: `comma_o` is high together with the strobe of each comma character detected while `det_en_i` is high, whether or not the framing moved. It is low for every other character.
- R7: `slot_o` toggles on every strobe, except that a comma character is always delivered with `slot_o` = 1. When the comma would otherwise land in slot 0, this forces a phase flip.
- R8: While `det_en_i` is low, framing and slot progression are held. Characters follow every 10 accepted bits from the existing boundary. Misplaced commas cause no reframing, and `comma_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Serial bit valid in this cycle |
| bit_i | input | 1 | Recovered serial bit |
| det_en_i | input | 1 | Enables comma search and realignment |
| char_o | output | 10 | Character, bit 0 received first |
| char_vld_o | output | 1 | One-cycle strobe per character |
| slot_o | output | 1 | Half-word slot of the current character |
| comma_o | output | 1 | Current character is a detected comma |

## Verification
The hardest case to reach from the ports is one where the framing is already good but must be broken and rebuilt. Detection is disabled, the framing is then displaced, and a comma must arrive in the wrong half-word slot. The stimulus first locks the block onto a stream that starts at a random bit offset. It then turns detection off, inserts a single stray bit, and checks that the displaced framing is kept and that the now-misplaced commas go unflagged. Finally it turns detection on again. Between commas it sends a random number of data characters, so commas fall in slot 0 and slot 1 in both the locked and the relocked streams.

// File: rtl/cdwa_pkg.sv
`timescale 1ns/1ps
package cdwa_pkg;
  typedef enum logic {
    SLOT_EVEN = 1'b0,
    SLOT_ODD  = 1'b1
  } slot_e;
endpackage

// File: rtl/cdwa_shift.sv
`timescale 1ns/1ps
module cdwa_shift #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              det_en_i,
  output logic [CHAR_W-1:0] sr_nxt_o,
  output logic              hit_o
);
  localparam int unsigned HIST_W = CHAR_W - 1;
  localparam int unsigned TAIL = CHAR_W - COMMA_W;

  logic [HIST_W-1:0]  hist_q;
  logic [COMMA_W-1:0] bit_eq;

  // newest bit enters at the top, oldest sits at bit 0
  assign sr_nxt_o = {bit_i, hist_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '0;
    else if (bit_en_i) hist_q <= sr_nxt_o[CHAR_W-1:1];
  end

  for (genvar i = 0; i < COMMA_W; i++) begin : g_cmp
    assign bit_eq[i] = (sr_nxt_o[TAIL+i] == COMMA_PAT[i]);
  end

  assign hit_o = bit_en_i & det_en_i & (&bit_eq);
endmodule

// File: rtl/cdwa_frame.sv
`timescale 1ns/1ps
module cdwa_frame
  import cdwa_pkg::*;
#(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned COMMA_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              hit_i,
  input  logic [CHAR_W-1:0] sr_nxt_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_vld_o,
  output logic              slot_o,
  output logic              comma_o
);
  localparam int unsigned CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAR_W - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMA_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d;
  logic              strobe;
  slot_e             slot_q;
  logic [CHAR_W-1:0] char_q;
  logic              vld_q, comma_q;

  assign strobe = bit_en_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (bit_en_i) begin
      // comma seen: boundary falls three bits after its last bit
      if (hit_i)       cnt_d = CNT_LOAD;
      else if (strobe) cnt_d = '0;
      else             cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (hit_i)       pend_d = 1'b1;
    else if (strobe) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      slot_q  <= SLOT_EVEN;
      char_q  <= '0;
      vld_q   <= 1'b0;
      comma_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      vld_q  <= strobe;
      if (strobe) begin
        char_q  <= sr_nxt_i;
        comma_q <= pend_q;
        slot_q  <= pend_q ? SLOT_ODD : slot_e'(~slot_q);
      end
    end
  end

  assign char_o     = char_q;
  assign char_vld_o = vld_q;
  assign slot_o     = slot_q;
  assign comma_o    = comma_q;
endmodule

// File: rtl/cdwa_align.sv
`timescale 1ns/1ps
module cdwa_align #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              det_en_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_vld_o,
  output logic              slot_o,
  output logic              comma_o
);
  logic [CHAR_W-1:0] sr_nxt;
  logic              hit;

  cdwa_shift #(
    .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
  ) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_i(bit_i),
    .det_en_i(det_en_i), .sr_nxt_o(sr_nxt), .hit_o(hit)
  );

  cdwa_frame #(
    .CHAR_W(CHAR_W), .COMMA_W(COMMA_W)
  ) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .hit_i(hit),
    .sr_nxt_i(sr_nxt), .char_o(char_o), .char_vld_o(char_vld_o),
    .slot_o(slot_o), .comma_o(comma_o)
  );
endmodule

// File: rtl/cdwa_align_chk.sv
`timescale 1ns/1ps
module cdwa_align_chk #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_en_i,
  input logic [CHAR_W-1:0] char_o,
  input logic              char_vld_o,
  input logic              slot_o,
  input logic              comma_o
);
  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_o |=> !char_vld_o);

  // R2
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_vld_o |-> ($stable(char_o) && $stable(slot_o) && $stable(comma_o)));

  // R3
  idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> !char_vld_o);

  // R5
  comma_framed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o && comma_o) |-> (char_o[COMMA_W-1:0] == COMMA_PAT));

  // R7
  comma_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o && comma_o) |-> slot_o);

  // R7
  slot_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o && !comma_o) |-> (slot_o != $past(slot_o)));
endmodule

bind cdwa_align cdwa_align_chk #(
  .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .char_o(char_o),
  .char_vld_o(char_vld_o), .slot_o(slot_o), .comma_o(comma_o)
);

// File: tb/sim_cdwa_align.sv
`timescale 1ns/1ps
module sim_cdwa_align;
  localparam logic [9:0] K_CH = 10'b0101111100;
  localparam int MAXB = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_d = 1'b0, det_en = 1'b0;
  logic [9:0] char_o;
  logic char_vld_o, slot_o, comma_o;

  int nchk = 0, nfail = 0, cyc = 0;
  logic bits [0:MAXB-1];
  logic det_at [0:MAXB-1];
  int nbits = 0;
  logic det_req = 1'b1;
  bit synced = 1'b0, armed = 1'b1, running = 1'b0;
  int resync_idx = 0, ptr = 0;
  logic last_slot = 1'b0;
  logic en_q = 1'b0;

  always #2 clk = ~clk;

  cdwa_align u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_d),
    .det_en_i(det_en), .char_o(char_o), .char_vld_o(char_vld_o),
    .slot_o(slot_o), .comma_o(comma_o)
  );

  function automatic logic [9:0] data_ch(int unsigned k);
    case (k % 4)
      0: return 10'b0101010101;
      1: return 10'b1010101010;
      2: return 10'b0010111001;
      default: return 10'b1101000110;
    endcase
  endfunction

  function automatic logic [9:0] exp_char(int p);
    logic [9:0] c;
    for (int k = 0; k < 10; k++) c[k] = bits[p+k];
    return c;
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    while ($urandom_range(3) == 0) begin
      @(negedge clk);
      bit_en = 1'b0;
      bit_d  = 1'($urandom_range(1));
    end
    @(negedge clk);
    bit_en = 1'b1;
    bit_d  = b;
    det_en = det_req;
    bits[nbits]   = b;
    det_at[nbits] = det_req;
    nbits++;
  endtask

  task automatic send_char(input logic [9:0] c, input bit is_k);
    if (is_k && armed) begin
      resync_idx = nbits;
      armed = 1'b0;
    end
    for (int k = 0; k < 10; k++) send_bit(c[k]);
  endtask

  task automatic send_block(input int n_commas);
    for (int i = 0; i < n_commas; i++) begin
      send_char(K_CH, 1'b1);
      for (int j = 0, nd = $urandom_range(1, 6); j < nd; j++)
        send_char(data_ch($urandom), 1'b0);
    end
  endtask

  always @(posedge clk) en_q <= bit_en;

  always @(negedge clk) begin
    if (rst_n && running) begin
      if (!en_q) begin
        nchk++;
        if (char_vld_o) begin
          nfail++;
          $display("FAIL R3 idle strobe: got 1 expected 0");
        end
      end
      if (char_vld_o) begin
        logic ec, es;
        logic [9:0] ex;
        if (!synced && comma_o) begin
          synced = 1'b1;
          ptr = resync_idx;
          check("R4 comma bits", {3'b0, char_o[6:0]}, 10'b0001111100);
        end
        ec = 1'b0;
        ex = '0;
        if (synced) begin
          ex = exp_char(ptr);
          ec = (ex[6:0] == 7'b1111100) && det_at[ptr+6];
          check(det_at[ptr+6] ? "R2 R5 char" : "R8 held char", char_o, ex);
          ptr += 10;
        end
        check(ec || !synced ? "R6 comma" : "R8 comma", {9'b0, comma_o}, {9'b0, ec});
        es = ec ? 1'b1 : ~last_slot;
        check("R7 slot", {9'b0, slot_o}, {9'b0, es});
        last_slot = es;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 char", char_o, 10'h000);
    check("R1 flags", {7'b0, char_vld_o, slot_o, comma_o}, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;

    // lock from a random bit offset; alternating filler holds no comma
    for (int i = 0, n = $urandom_range(0, 19); i < n; i++) send_bit(1'(i % 2));
    send_block(8);

    // R8: freeze, then slip the stream by one bit
    det_req = 1'b0;
    send_bit(1'($urandom_range(1)));
    send_block(6);

    // relock
    det_req = 1'b1;
    synced  = 1'b0;
    armed   = 1'b1;
    send_block(8);
    for (int i = 0; i < 4; i++) send_char(data_ch(i), 1'b0);
    @(negedge clk);
    bit_en = 1'b0;
    repeat (20) @(negedge clk);

    nchk++;
    if (!synced) begin
      nfail++;
      $display("FAIL R5 relock: got 0 expected 1");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule